// File: doc/BRIEF.md
# Pointer-Addressed Control Register Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial bus (I2C/SMBus style). A host uses it to read and write a small bank of 8-bit control registers, and core logic reads every register in parallel through a flat output vector. The block samples the clock and data lines with the system clock through a synchronizer and detects start and stop conditions from the synchronized levels. Bytes are received on rising bus-clock edges. The block changes its own open-drain data drive only after a falling bus-clock edge.

The device address is seven bits wide. Its upper six bits are fixed by a parameter, and its lowest bit follows a strapping input. A write transaction carries the address, then a pointer byte, then data bytes, and the pointer steps forward after every data byte. A read transaction first sets the pointer in a write, then sends a repeated start and the address with the read direction. The block then returns the selected register and continues for as long as the host acknowledges. Register index 15 does not exist. Any access that targets it is refused with a not-acknowledge.

Top module: `i2cCtrlRegs`

## Requirements
- R1: After reset, all fifteen registers read 0x00 on `regFlat` (register n occupies bits 8n+7..8n), and `sdaDriveLow` is 0 (SDA released).
- R2: The block acknowledges an address byte, by driving SDA low during the ninth clock pulse, only when the byte's upper seven bits equal {ADDR_HI, addrSel}. Any other address gets no acknowledge, and the rest of that transaction is ignored: no register changes and no SDA drive.
- R3: In a write (direction bit 0), the second byte sets the pointer from its low four bits, and its upper four bits are ignored. Each following byte is received MSB first, stored into the register the pointer selects, and acknowledged.
- R4: The pointer increments by one after each data byte that is written, so a burst of bytes fills consecutive registers.
- R5: In a read (direction bit 1, usually after a repeated start), the block shifts out the selected register MSB first. It changes SDA only while SCL is low. The pointer increments after each byte, and the next byte follows whenever the host acknowledges.
- R6: When the host leaves SDA high in the acknowledge slot of a read, the block stops driving. SDA then stays released, so further clock pulses read as all ones.
- R7: Index 0x0F is refused. A pointer byte whose low four bits are 0xF is not acknowledged. A data byte sent while the pointer is 0xF is neither stored nor acknowledged. A read address is not acknowledged while the pointer is 0xF. The pointer never steps past 0xF. In a read burst that runs onto 0xF, the block sends 0xFF (SDA released).
- R8: A stop condition returns the block to idle and keeps the pointer value. A later read that carries no pointer byte starts at that held pointer.
- R9: A start condition at any point, including in the middle of a byte or during an ignored transaction, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired value) |
| addrSel | input | 1 | Strap that sets the lowest device address bit |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it (open-drain enable) |
| regFlat | output | REG_COUNT*DATA_W | All registers, register n at bits n*DATA_W +: DATA_W |

## Verification
Address bytes are tried with the strap at both levels, each with the matching and the non-matching address. This separates a correct strap decode from a fixed address. Write bursts with mixed bit patterns, including a pointer byte with a non-zero upper nibble, show whether data lands in consecutive registers and whether the nibble is ignored. Read bursts are tried with host acknowledge and with host not-acknowledge, and they start both from a fresh pointer and from a pointer held across a stop. These runs separate pointer stepping, end of data and pointer retention. Bursts that run into index 0x0F, together with starts issued mid-byte and mid-ignore, check the refusal and restart paths.

// File: rtl/i2cCtrlPkg.sv
package i2cCtrlPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLevel;
  } busEvents_t;

  typedef struct packed {
    logic shiftIn;
    logic ptrLoad;
    logic regWrite;
    logic txLoad;
    logic txShift;
    logic ptrStep;
  } dpStrobes_t;

endpackage

// File: rtl/i2cCtrlSync.sv
module i2cCtrlSync
  import i2cCtrlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output busEvents_t ev,
  output logic       sclLevel
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  always_comb begin
    ev.sclRise   = sclNow & ~sclOld;
    ev.sclFall   = ~sclNow & sclOld;
    ev.startSeen = sclNow & sclOld & sdaOld & ~sdaNow;
    ev.stopSeen  = sclNow & sclOld & ~sdaOld & sdaNow;
    ev.sdaLevel  = sdaNow;
  end

  assign sclLevel = sclNow;

endmodule

// File: rtl/i2cCtrlData.sv
module i2cCtrlData
  import i2cCtrlPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 4,
  parameter int REG_COUNT = 15
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobes_t                  stb,
  input  logic                        sdaBit,
  output logic [DATA_W-1:0]           rxByte,
  output logic [PTR_W-1:0]            curPtr,
  output logic                        ptrAtLimit,
  output logic                        txFirst,
  output logic                        txNextBit,
  output logic [REG_COUNT*DATA_W-1:0] regFlat
);

  localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(REG_COUNT);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] regAtPtr;

  assign ptrAtLimit = (curPtr == PTR_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (stb.shiftIn) begin
      rxByte <= {rxByte[DATA_W-2:0], sdaBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0;
    end else if (stb.ptrLoad) begin
      curPtr <= rxByte[PTR_W-1:0];
    end else if ((stb.regWrite || stb.ptrStep) && !ptrAtLimit) begin
      curPtr <= curPtr + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          regs[g] <= '0;
        end else if (stb.regWrite && curPtr == PTR_W'(g)) begin
          regs[g] <= rxByte;
        end
      end
      assign regFlat[g*DATA_W +: DATA_W] = regs[g];
    end
  endgenerate

  always_comb begin
    regAtPtr = '1;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (curPtr == PTR_W'(i)) regAtPtr = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '1;
    end else if (stb.txLoad) begin
      txReg <= regAtPtr;
    end else if (stb.txShift) begin
      txReg <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  assign txFirst   = regAtPtr[DATA_W-1];
  assign txNextBit = txReg[DATA_W-2];

endmodule

// File: rtl/i2cCtrlFsm.sv
module i2cCtrlFsm
  import i2cCtrlPkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          PTR_W   = 4,
  parameter logic [5:0]  ADDR_HI = 6'b100110
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvents_t        ev,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              ptrAtLimit,
  input  logic              txFirst,
  input  logic              txNextBit,
  output dpStrobes_t        stb,
  output logic              sdaLow,
  output busState_t         stateOut
);

  localparam int                CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DATA_W);

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             readDir;
  logic             masterAck;

  logic byteDone, addrHit, dirBit, ptrOk, receiving;

  assign byteDone  = ev.sclFall && (bitCnt == FULL);
  assign addrHit   = (rxByte[DATA_W-1:DATA_W-7] == {ADDR_HI, addrSel});
  assign dirBit    = rxByte[0];
  assign ptrOk     = (rxByte[PTR_W-1:0] != {PTR_W{1'b1}});
  assign receiving = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign stateOut  = state;

  always_comb begin
    stb          = '0;
    stb.shiftIn  = ev.sclRise && receiving;
    stb.ptrLoad  = byteDone && (state == ST_PTR);
    stb.regWrite = byteDone && (state == ST_WDATA) && !ptrAtLimit;
    stb.txLoad   = ev.sclFall && (((state == ST_AACK) && readDir) ||
                                  ((state == ST_RACK) && masterAck));
    stb.txShift  = ev.sclFall && (state == ST_RDATA) && (bitCnt != '0) && (bitCnt != FULL);
    stb.ptrStep  = byteDone && (state == ST_RDATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readDir   <= 1'b0;
      masterAck <= 1'b0;
      sdaLow    <= 1'b0;
    end else if (ev.startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (ev.stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else begin
      if (ev.sclRise && (receiving || state == ST_RDATA)) bitCnt <= bitCnt + 1'b1;
      if (ev.sclRise && state == ST_RACK) masterAck <= !ev.sdaLevel;
      if (ev.sclFall) begin
        case (state)
          ST_ADDR: if (bitCnt == FULL) begin
            if (addrHit && !(dirBit && ptrAtLimit)) begin
              sdaLow  <= 1'b1;
              readDir <= dirBit;
              state   <= ST_AACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_AACK: begin
            bitCnt <= '0;
            if (readDir) begin
              sdaLow <= !txFirst;
              state  <= ST_RDATA;
            end else begin
              sdaLow <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_PTR: if (bitCnt == FULL) begin
            if (ptrOk) begin
              sdaLow <= 1'b1;
              state  <= ST_PACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_PACK, ST_WACK: begin
            sdaLow <= 1'b0;
            bitCnt <= '0;
            state  <= ST_WDATA;
          end
          ST_WDATA: if (bitCnt == FULL) begin
            if (!ptrAtLimit) begin
              sdaLow <= 1'b1;
              state  <= ST_WACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_RDATA: begin
            if (bitCnt == FULL) begin
              sdaLow <= 1'b0;
              state  <= ST_RACK;
            end else if (bitCnt != '0) begin
              sdaLow <= !txNextBit;
            end
          end
          ST_RACK: begin
            if (masterAck) begin
              sdaLow <= !txFirst;
              bitCnt <= '0;
              state  <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cCtrlRegs.sv
module i2cCtrlRegs
  import i2cCtrlPkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         PTR_W       = 4,
  parameter int         REG_COUNT   = 15,
  parameter logic [5:0] ADDR_HI     = 6'b100110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  logic                        addrSel,
  output logic                        sdaDriveLow,
  output logic [REG_COUNT*DATA_W-1:0] regFlat
);

  busEvents_t        busEv;
  dpStrobes_t        dpStb;
  busState_t         fsmState;
  logic              sclLevel;
  logic [DATA_W-1:0] rxByte;
  logic [PTR_W-1:0]  curPtr;
  logic              ptrAtLimit, txFirst, txNextBit;
  logic              isIgnoring;

  assign isIgnoring = (fsmState == ST_IGNORE);

  i2cCtrlSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ev(busEv), .sclLevel(sclLevel)
  );

  i2cCtrlFsm #(.DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_HI(ADDR_HI)) uFsm (
    .clk(clk), .rstN(rstN), .ev(busEv), .addrSel(addrSel), .rxByte(rxByte),
    .ptrAtLimit(ptrAtLimit), .txFirst(txFirst), .txNextBit(txNextBit),
    .stb(dpStb), .sdaLow(sdaDriveLow), .stateOut(fsmState)
  );

  i2cCtrlData #(.DATA_W(DATA_W), .PTR_W(PTR_W), .REG_COUNT(REG_COUNT)) uData (
    .clk(clk), .rstN(rstN), .stb(dpStb), .sdaBit(busEv.sdaLevel),
    .rxByte(rxByte), .curPtr(curPtr), .ptrAtLimit(ptrAtLimit),
    .txFirst(txFirst), .txNextBit(txNextBit), .regFlat(regFlat)
  );

endmodule

// File: rtl/i2cCtrlChecker.sv
module i2cCtrlChecker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdaDriveLow,
  input logic             sclLevel,
  input logic             startSeen,
  input logic             stopSeen,
  input logic [PTR_W-1:0] curPtr,
  input logic             regWrite,
  input logic             ptrLoad,
  input logic             isIgnoring
);

  // R5: the slave changes its SDA drive only while SCL is low (except when a start or stop forces a release)
  assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(startSeen) && !$past(stopSeen)) |-> !sclLevel);

  // R8: a stop leaves SDA released
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaDriveLow);

  // R2 / R6: an ignored transaction never pulls SDA
  assert_ignore_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    isIgnoring |-> !sdaDriveLow);

  // R7: no store happens while the pointer sits on index 0xF
  assert_no_store_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> (curPtr != {PTR_W{1'b1}}));

  // R7: the pointer holds at 0xF unless it is reloaded
  assert_ptr_saturate_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((curPtr == {PTR_W{1'b1}}) && !ptrLoad) |=> (curPtr == {PTR_W{1'b1}}));

  // R4: each stored byte advances the pointer by one
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> (curPtr == $past(curPtr) + 1'b1));

endmodule

bind i2cCtrlRegs i2cCtrlChecker #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .sclLevel(sclLevel),
  .startSeen(busEv.startSeen), .stopSeen(busEv.stopSeen), .curPtr(curPtr),
  .regWrite(dpStb.regWrite), .ptrLoad(dpStb.ptrLoad), .isIgnoring(isIgnoring)
);

// File: tb/test_i2cCtrlRegs.sv
`timescale 1ns/1ps
module test_i2cCtrlRegs;

  localparam int Q = 10;
  localparam logic [7:0] WR0 = 8'h98;  // address 0x4C, write
  localparam logic [7:0] RD0 = 8'h99;  // address 0x4C, read
  localparam logic [7:0] WR1 = 8'h9A;  // address 0x4D, write

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic addrSel = 1'b0;
  logic sdaDriveLow;
  logic [119:0] regFlat;
  logic sdaWire;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [15];

  always #2 clk = ~clk;

  assign sdaWire = mSda & ~sdaDriveLow;

  i2cCtrlRegs i_i2cCtrlRegs (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaWire), .addrSel(addrSel),
    .sdaDriveLow(sdaDriveLow), .regFlat(regFlat)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < 15; i++) check(tag, {24'h0, regFlat[i*8 +: 8]}, {24'h0, model[i]});
  endtask

  task automatic busBit(input logic b, output logic seen);
    tick(2); mSda = b; tick(Q); mScl = 1'b1; tick(Q); seen = sdaWire; tick(Q); mScl = 1'b0;
  endtask

  task automatic startCond();
    if (!mScl) begin
      tick(2); mSda = 1'b1; tick(Q); mScl = 1'b1; tick(Q);
    end
    mSda = 1'b0; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    tick(2); mSda = 1'b0; tick(Q); mScl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(v[i], s);
    busBit(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, s);
      v[i] = s;
    end
    busBit(!giveAck, s);
  endtask

  task automatic testReset();
    check("R1 regs zero", {8'h0, regFlat[23:0]}, 32'h0);
    checkRegs("R1 regs zero");
    check("R1 sda released", {31'h0, sdaDriveLow}, 32'h0);
  endtask

  task automatic testAddress();
    logic a;
    addrSel = 1'b0;
    startCond(); sendByte(WR0, a); stopCond(); check("R2 match sel0", {31'h0, a}, 32'h1);
    startCond(); sendByte(WR1, a); stopCond(); check("R2 mismatch sel0", {31'h0, a}, 32'h0);
    addrSel = 1'b1; tick(4);
    startCond(); sendByte(WR1, a); stopCond(); check("R2 match sel1", {31'h0, a}, 32'h1);
    startCond(); sendByte(WR0, a); stopCond(); check("R2 mismatch sel1", {31'h0, a}, 32'h0);
    addrSel = 1'b0; tick(4);
  endtask

  task automatic testIgnoreMismatch();
    logic a, b, c;
    startCond(); sendByte(WR1, a); sendByte(8'h01, b); sendByte(8'h11, c); stopCond();
    check("R2 mismatch addr nack", {31'h0, a}, 32'h0);
    check("R2 ignored bytes nack", {30'h0, b, c}, 32'h0);
    checkRegs("R2 ignored no write");
  endtask

  task automatic testWriteBurst();
    logic a, p, d0, d1, d2;
    startCond(); sendByte(WR0, a); sendByte(8'h03, p);
    sendByte(8'hA5, d0); sendByte(8'h3C, d1); sendByte(8'h0F, d2); stopCond();
    model[3] = 8'hA5; model[4] = 8'h3C; model[5] = 8'h0F;
    check("R3 data acks", {27'h0, a, p, d0, d1, d2}, 32'h1F);
    check("R3 reg3", {24'h0, regFlat[31:24]}, 32'hA5);
    check("R4 reg4", {24'h0, regFlat[39:32]}, 32'h3C);
    check("R4 reg5", {24'h0, regFlat[47:40]}, 32'h0F);
    startCond(); sendByte(WR0, a); sendByte(8'hF2, p); sendByte(8'h77, d0); stopCond();
    model[2] = 8'h77;
    check("R3 upper nibble ignored ack", {29'h0, a, p, d0}, 32'h7);
    checkRegs("R3 upper nibble ignored");
  endtask

  task automatic testReadBurst();
    logic a, p, r;
    logic [7:0] v0, v1, v2, v3;
    startCond(); sendByte(WR0, a); sendByte(8'h03, p);
    startCond(); sendByte(RD0, r);
    readByte(1'b1, v0); readByte(1'b1, v1); readByte(1'b0, v2);
    check("R5 read addr ack", {29'h0, a, p, r}, 32'h7);
    check("R5 read byte0", {24'h0, v0}, 32'hA5);
    check("R5 read byte1", {24'h0, v1}, 32'h3C);
    check("R5 read byte2", {24'h0, v2}, 32'h0F);
    tick(Q);
    check("R6 released after nack", {31'h0, sdaDriveLow}, 32'h0);
    readByte(1'b0, v3);
    check("R6 no drive after nack", {24'h0, v3}, 32'hFF);
    stopCond();
  endtask

  task automatic testStopKeepsPtr();
    logic a, p, r;
    logic [7:0] v;
    startCond(); sendByte(WR0, a); sendByte(8'h04, p); stopCond();
    startCond(); sendByte(RD0, r); readByte(1'b0, v); stopCond();
    check("R8 held ptr read", {24'h0, v}, 32'h3C);
    startCond(); sendByte(RD0, r); readByte(1'b0, v); stopCond();
    check("R8 ptr stepped by read", {24'h0, v}, 32'h0F);
  endtask

  task automatic testLimit();
    logic a, p, d0, d1, r;
    logic [7:0] v0, v1;
    startCond(); sendByte(WR0, a); sendByte(8'h0E, p); sendByte(8'h5A, d0); sendByte(8'h66, d1); stopCond();
    model[14] = 8'h5A;
    check("R7 last valid ack", {30'h0, p, d0}, 32'h3);
    check("R7 index F data nack", {31'h0, d1}, 32'h0);
    checkRegs("R7 index F not stored");
    startCond(); sendByte(RD0, r); stopCond();
    check("R7 read addr nack at F", {31'h0, r}, 32'h0);
    startCond(); sendByte(WR0, a); sendByte(8'h0F, p); stopCond();
    check("R7 pointer F nack", {31'h0, p}, 32'h0);
    startCond(); sendByte(WR0, a); sendByte(8'h0E, p);
    startCond(); sendByte(RD0, r); readByte(1'b1, v0); readByte(1'b0, v1); stopCond();
    check("R7 read 0E", {24'h0, v0}, 32'h5A);
    check("R7 read past end ones", {24'h0, v1}, 32'hFF);
  endtask

  task automatic testRestart();
    logic a, b, p, d, s;
    startCond(); sendByte(WR1, a);
    startCond(); sendByte(WR0, b); sendByte(8'h00, p); sendByte(8'hC3, d); stopCond();
    model[0] = 8'hC3;
    check("R9 restart after ignore", {28'h0, a, b, p, d}, 32'h7);
    check("R9 reg0", {24'h0, regFlat[7:0]}, 32'hC3);
    startCond(); sendByte(WR0, a);
    busBit(1'b1, s); busBit(1'b0, s); busBit(1'b1, s); busBit(1'b1, s);
    startCond(); sendByte(WR0, b); sendByte(8'h01, p); sendByte(8'h81, d); stopCond();
    model[1] = 8'h81;
    check("R9 restart mid byte acks", {29'h0, b, p, d}, 32'h7);
    checkRegs("R9 restart mid byte");
  endtask

  initial begin
    for (int i = 0; i < 15; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testAddress();
    testIgnoreMismatch();
    testWriteBurst();
    testReadBurst();
    testStopKeepsPtr();
    testLimit();
    testRestart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule